// File: doc/BRIEF.md
# External Edge Interrupt Line Mapper

This block watches sixteen external input lines. Each line can be set to trigger on a low level, on any edge, on a falling edge or on a rising edge. Each trigger is recorded in a per-line pending bit, and the pending bits are folded into seven interrupt request outputs. Lines 0 to 4 each own a request output. Lines 5 to 9 share one output, and lines 10 to 15 share another.

A handler for a shared output reads the pending vector to see which lines caused the request. Several lines can be pending behind one output at once, and each stays visible until software clears it by writing a one to its bit. A per-line mask gates only the request outputs. Pending bits keep latching while a line is masked, so a trigger that arrives while masked is seen once the mask is opened.

Top module: `edge_irq_mapper`

## Requirements
- R1: Each input passes through two synchronising flops. A transition applied before clock edge k sets the line's pending bit at edge k+2 and not earlier.
- R2: The two-bit trigger field of line n is `trig_sel_i[2n+1:2n]`. Its codes are 00 for low level (pending sets on every cycle the synchronised line is 0), 01 for any edge, 10 for falling edge and 11 for rising edge.
- R3: A pending bit, once set, stays set until it is cleared. It latches whatever the line's mask bit is.
- R4: A 1 on `clr_i[n]` clears pending bit n at the next edge. A 0 leaves the bit as it is.
- R5: If a trigger and a clear reach the same line in the same cycle, the pending bit stays set.
- R6: For n in 0..4, `irq_o[n]` is high exactly when pending bit n and mask bit n are both 1. A mask value of 0b11 enables lines 0 and 1 only.
- R7: `irq_o[5]` is high exactly when any of lines 5..9 is pending and unmasked.
- R8: `irq_o[6]` is high exactly when any of lines 10..15 is pending and unmasked.
- R9: While reset is low and after it is released, all pending bits and request outputs are 0 until a trigger occurs.
- R10: Several pending lines behind one shared output are all visible in `pending_o`. Clearing one of them keeps the shared output high while another unmasked line in that group is still pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| line_i | input | 16 | Asynchronous external lines |
| trig_sel_i | input | 32 | Two-bit trigger select per line |
| mask_i | input | 16 | Per-line request enable |
| clr_i | input | 16 | Write-one-to-clear strobes for pending bits |
| pending_o | output | 16 | Pending status per line |
| irq_o | output | 7 | Request outputs: 0..4 dedicated, 5 for lines 5..9, 6 for lines 10..15 |

## Verification
The bound checker looks at every cycle and every line. It checks that a pending bit holds unless cleared, that a detected trigger always leaves the bit set even with a simultaneous clear, that a clear with no trigger drops the bit, and that no bit rises without a detection. It also checks that each request output matches its group's pending-and-unmasked lines. Only the bench scenarios can show the two-flop latency from the pins, how each trigger code reacts to real waveforms, and several lines stacking up behind one shared output and being cleared one at a time.

// File: rtl/eim_pkg.sv
package eim_pkg;
  typedef enum logic [1:0] {
    TRIG_LOW  = 2'b00,
    TRIG_ANY  = 2'b01,
    TRIG_FALL = 2'b10,
    TRIG_RISE = 2'b11
  } trig_e;

  localparam int unsigned NUM_LINES     = 16;
  localparam int unsigned NUM_DEDICATED = 5;
  localparam int unsigned SPLIT_LINE    = 10;  // first line of the second shared group
  localparam int unsigned NUM_IRQ       = NUM_DEDICATED + 2;

  function automatic int unsigned irq_of_line(int unsigned ln);
    if (ln < NUM_DEDICATED) return ln;
    else if (ln < SPLIT_LINE) return NUM_DEDICATED;
    else return NUM_DEDICATED + 1;
  endfunction
endpackage

// File: rtl/eim_sync.sv
module eim_sync #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stage1_q, stage2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_i;
      stage2_q <= stage1_q;
    end
  end

  assign sync_o = stage2_q;
endmodule

// File: rtl/eim_detect.sv
module eim_detect
  import eim_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [W-1:0]   sync_i,
  input  logic [2*W-1:0] trig_sel_i,
  output logic [W-1:0]   hit_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= sync_i;
  end

  for (genvar i = 0; i < W; i++) begin : g_line
    trig_e mode;
    assign mode = trig_e'(trig_sel_i[2*i +: 2]);
    always_comb begin
      unique case (mode)
        TRIG_LOW:  hit_o[i] = ~sync_i[i];
        TRIG_ANY:  hit_o[i] = sync_i[i] ^ prev_q[i];
        TRIG_FALL: hit_o[i] = prev_q[i] & ~sync_i[i];
        default:   hit_o[i] = sync_i[i] & ~prev_q[i];
      endcase
    end
  end
endmodule

// File: rtl/eim_pending.sv
module eim_pending #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] hit_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] pend_q;

  // set dominates clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_i) | hit_i;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/eim_route.sv
module eim_route
  import eim_pkg::*;
#(
  parameter int unsigned W    = NUM_LINES,
  parameter int unsigned NIRQ = NUM_IRQ
) (
  input  logic [W-1:0]    pend_i,
  input  logic [W-1:0]    mask_i,
  output logic [NIRQ-1:0] irq_o
);
  function automatic logic [W-1:0] members(int unsigned k);
    logic [W-1:0] m;
    m = '0;
    for (int unsigned ln = 0; ln < W; ln++) m[ln] = (irq_of_line(ln) == k);
    return m;
  endfunction

  logic [W-1:0] live;
  assign live = pend_i & mask_i;

  for (genvar k = 0; k < NIRQ; k++) begin : g_irq
    localparam logic [W-1:0] MEMB = members(k);
    assign irq_o[k] = |(live & MEMB);
  end
endmodule

// File: rtl/edge_irq_mapper.sv
module edge_irq_mapper
  import eim_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NUM_LINES-1:0]   line_i,
  input  logic [2*NUM_LINES-1:0] trig_sel_i,
  input  logic [NUM_LINES-1:0]   mask_i,
  input  logic [NUM_LINES-1:0]   clr_i,
  output logic [NUM_LINES-1:0]   pending_o,
  output logic [NUM_IRQ-1:0]     irq_o
);
  logic [NUM_LINES-1:0] line_sync;
  logic [NUM_LINES-1:0] line_hit;

  eim_sync #(.W(NUM_LINES)) u_sync (
    .clk_i, .rst_ni, .async_i(line_i), .sync_o(line_sync)
  );

  eim_detect #(.W(NUM_LINES)) u_detect (
    .clk_i, .rst_ni, .sync_i(line_sync), .trig_sel_i, .hit_o(line_hit)
  );

  eim_pending #(.W(NUM_LINES)) u_pend (
    .clk_i, .rst_ni, .hit_i(line_hit), .clr_i, .pend_o(pending_o)
  );

  eim_route #(.W(NUM_LINES), .NIRQ(NUM_IRQ)) u_route (
    .pend_i(pending_o), .mask_i, .irq_o
  );
endmodule

// File: rtl/eim_checker.sv
module eim_checker
  import eim_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [NUM_LINES-1:0] mask_i,
  input logic [NUM_LINES-1:0] clr_i,
  input logic [NUM_LINES-1:0] hit_i,
  input logic [NUM_LINES-1:0] pending_i,
  input logic [NUM_IRQ-1:0]   irq_i
);
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_chk
    a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pending_i[i] && !clr_i[i]) |=> pending_i[i]);
    a_r5_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_i[i] |=> pending_i[i]);
    a_r4_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[i] && !hit_i[i]) |=> !pending_i[i]);
    a_r1_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!pending_i[i] && !hit_i[i]) |=> !pending_i[i]);
  end

  a_r6_dedicated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i[NUM_DEDICATED-1:0] == (pending_i[NUM_DEDICATED-1:0] & mask_i[NUM_DEDICATED-1:0]));
  a_r7_group_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i[NUM_DEDICATED] == |(pending_i[SPLIT_LINE-1:NUM_DEDICATED] & mask_i[SPLIT_LINE-1:NUM_DEDICATED]));
  a_r8_group_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i[NUM_DEDICATED+1] == |(pending_i[NUM_LINES-1:SPLIT_LINE] & mask_i[NUM_LINES-1:SPLIT_LINE]));
endmodule

bind edge_irq_mapper eim_checker u_eim_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .mask_i    (mask_i),
  .clr_i     (clr_i),
  .hit_i     (line_hit),
  .pending_i (pending_o),
  .irq_i     (irq_o)
);

// File: tb/test_edge_irq_mapper.sv
`timescale 1ns/1ps
module test_edge_irq_mapper;
  localparam int NL = 16;
  localparam int NI = 7;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NL-1:0]   line = '0;
  logic [2*NL-1:0] trig = '1;
  logic [NL-1:0]   mask = '1;
  logic [NL-1:0]   clr = '0;
  logic [NL-1:0]   pending;
  logic [NI-1:0]   irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  edge_irq_mapper i_edge_irq_mapper (
    .clk_i(clk), .rst_ni(rst_n), .line_i(line), .trig_sel_i(trig),
    .mask_i(mask), .clr_i(clr), .pending_o(pending), .irq_o(irq)
  );

  // reference model from the requirements
  logic [NL-1:0] m_s1, m_s2, m_s3, m_pend;

  function automatic logic hit_ref(logic cur, logic prev, logic [1:0] ts);
    case (ts)
      2'b00:   return ~cur;
      2'b01:   return cur ^ prev;
      2'b10:   return prev & ~cur;
      default: return cur & ~prev;
    endcase
  endfunction

  function automatic logic [NI-1:0] irq_ref(logic [NL-1:0] p, logic [NL-1:0] m);
    logic [NL-1:0] v;
    logic [NI-1:0] r;
    v = p & m;
    r[4:0] = v[4:0];
    r[5] = |v[9:5];
    r[6] = |v[15:10];
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_s3 <= '0; m_pend <= '0;
    end else begin
      logic [NL-1:0] h;
      for (int i = 0; i < NL; i++) h[i] = hit_ref(m_s2[i], m_s3[i], trig[2*i +: 2]);
      m_s1 <= line;
      m_s2 <= m_s1;
      m_s3 <= m_s2;
      m_pend <= (m_pend & ~clr) | h;
    end
  end

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // advance to next negedge and compare against the model
  task automatic step();
    logic [NI-1:0] e;
    @(negedge clk);
    check(pending === m_pend, "R3 pending", 32'(pending), 32'(m_pend));
    e = irq_ref(m_pend, mask);
    for (int k = 0; k < NI; k++)
      if (irq[k] !== e[k])
        check(0, k < 5 ? "R6 dedicated irq" : (k == 5 ? "R7 group irq" : "R8 group irq"),
              32'(irq), 32'(e));
    total++;
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic clear_all();
    clr = '1; step(); clr = '0; step();
  endtask

  initial begin
    #400000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234abcd));
    repeat (3) @(negedge clk);
    check(pending === '0 && irq === '0, "R9 reset", 32'({irq, pending}), 32'h0);
    rst_n = 1'b1;
    steps(4);
    check(pending === '0 && irq === '0, "R9 after release", 32'({irq, pending}), 32'h0);

    // R1 latency: rising edge on line 0
    line[0] = 1'b1;
    step(); check(pending[0] === 1'b0, "R1 edge+1", 32'(pending[0]), 32'h0);
    step(); check(pending[0] === 1'b0, "R1 edge+2", 32'(pending[0]), 32'h0);
    step(); check(pending[0] === 1'b1, "R1 edge+3", 32'(pending[0]), 32'h1);
    check(irq[0] === 1'b1, "R6 irq0 up", 32'(irq[0]), 32'h1);

    // R3 masked line still latches; R6 mask 0b11
    mask = 16'h0003;
    line[2] = 1'b1; steps(4);
    check(pending[2] === 1'b1, "R3 latch while masked", 32'(pending[2]), 32'h1);
    check(irq[2] === 1'b0 && irq[0] === 1'b1, "R6 mask 0b11", 32'(irq), 32'h1);
    mask = '1; step();
    check(irq[2] === 1'b1, "R6 unmask shows latched", 32'(irq[2]), 32'h1);
    clear_all();
    check(pending === '0, "R4 clear all", 32'(pending), 32'h0);

    // R2 falling mode on line 3: the rise must not set
    trig[7:6] = 2'b10; line[3] = 1'b1; steps(4);
    check(pending[3] === 1'b0, "R2 fall ignores rise", 32'(pending[3]), 32'h0);
    line[3] = 1'b0; steps(4);
    check(pending[3] === 1'b1, "R2 fall sets", 32'(pending[3]), 32'h1);
    // any-edge on line 4
    trig[9:8] = 2'b01; line[4] = 1'b1; steps(4);
    check(pending[4] === 1'b1, "R2 any edge", 32'(pending[4]), 32'h1);
    clear_all();

    // R10 two lines behind shared output 5
    line[5] = 1'b1; line[7] = 1'b1; steps(4);
    check(pending[9:5] === 5'b00101, "R10 both visible", 32'(pending[9:5]), 32'h5);
    clr[5] = 1'b1; step(); clr = '0; step();
    check(pending[7] === 1'b1 && irq[5] === 1'b1, "R10 other keeps irq", 32'(irq), 32'h20);
    clr[7] = 1'b1; step(); clr = '0; step();
    check(irq[5] === 1'b0, "R7 group drops", 32'(irq[5]), 32'h0);

    // R8 group of lines 10..15
    line[15] = 1'b1; steps(4);
    check(irq[6] === 1'b1 && irq[5:0] === '0, "R8 group up", 32'(irq), 32'h40);
    clr[15] = 1'b1; step(); clr = '0; step();
    check(irq[6] === 1'b0, "R8 group drops", 32'(irq[6]), 32'h0);

    // R5 low level on line 12 with a constant clear: set wins
    trig[25:24] = 2'b00; line[12] = 1'b0; clr[12] = 1'b1; steps(4);
    check(pending[12] === 1'b1, "R5 set beats clear", 32'(pending[12]), 32'h1);
    clr = '0; trig = '1; clear_all();

    // constrained random
    for (int c = 0; c < 3000; c++) begin
      for (int i = 0; i < NL; i++) if ($urandom_range(15) == 0) line[i] = ~line[i];
      if ($urandom_range(63) == 0) trig = {$urandom(), $urandom()} | {NL{2'b01}};
      if ($urandom_range(31) == 0) mask = 16'($urandom());
      clr = ($urandom_range(3) == 0) ? 16'($urandom()) : '0;
      step();
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule